// File: doc/BRIEF.md
# Boot Source Select and Vector Page Remap

This unit records which flash region the device will start from next and moves the low vector page of the CPU address space onto a chosen flash page. A two-bit boot configuration value says two things. It names the start region, with the high bit set for the application region and clear for the loader region. It also says whether in-application programming (IAP) is on, with the low bit clear meaning IAP is on. A one-bit boot-select register holds the next start region. Software can change that register. Each full reset loads it again from the configuration. A reset that is marked as a CPU-only or system reset leaves it unchanged, so a boot switch that software asked for survives that reset.

A remap request carries a flash address. When the request is accepted, bits [20:9] of that address become the current 12-bit remap page. While IAP is on, CPU fetch addresses below 0x200 are turned into `{page, offset[8:0]}`. All other fetch addresses reach the flash unchanged. A read-only status word shows the configuration value and the remap page at fixed bit positions.

Top module: `bootmap_unit`

## Requirements
- R1: On a clock edge with `rst_n` low and both `rst_cpu` and `rst_sys` low, `boot_sel` becomes the inverse of `boot_cfg[1]` (1 = loader region, 0 = application region) and `remap_page` becomes 0.
- R2: On a clock edge with `rst_n` low and `rst_cpu` or `rst_sys` high, `boot_sel` and `remap_page` keep their values.
- R3: With `rst_n` high, `bs_wr_en` high loads `bs_wr_val` into `boot_sel` on the next edge. With `bs_wr_en` low, `boot_sel` holds its value.
- R4: With `rst_n` high, a `remap_req` is accepted and loads `remap_addr[20:9]` into `remap_page` on the next edge when three conditions hold: `boot_cfg[0]` is 0 (an IAP mode), `remap_addr[8:0]` is 0, and `remap_addr[31:21]` is 0.
- R5: A `remap_req` made while `boot_cfg[0]` is 1 (a non-IAP mode) leaves `remap_page` unchanged.
- R6: A `remap_req` whose address has any of bits [8:0] set, or any of bits [31:21] set, leaves `remap_page` unchanged.
- R7: While `boot_cfg[0]` is 0 and `fetch_addr` is below 0x200, `phys_addr` equals `{11'b0, remap_page, fetch_addr[8:0]}`, combinationally.
- R8: A `fetch_addr` of 0x200 or above appears unchanged on `phys_addr`.
- R9: While `boot_cfg[0]` is 1, every `fetch_addr` appears unchanged on `phys_addr`.
- R10: `status_word` bits [2:1] equal `boot_cfg`, bits [20:9] equal `remap_page`, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_cpu | input | 1 | The current reset is a CPU-only reset |
| rst_sys | input | 1 | The current reset is a system reset |
| boot_cfg | input | 2 | Boot configuration: bit 1 selects the region (1 = application), bit 0 disables IAP |
| bs_wr_en | input | 1 | Software write strobe for the boot-select bit |
| bs_wr_val | input | 1 | Value written to the boot-select bit |
| remap_req | input | 1 | Remap command strobe |
| remap_addr | input | 32 | Flash address carried by the remap command |
| fetch_addr | input | 32 | CPU fetch address |
| boot_sel | output | 1 | Next boot region: 1 = loader, 0 = application |
| remap_page | output | 12 | Current vector remap page |
| status_word | output | 32 | Read-only status: configuration at [2:1], page at [20:9] |
| phys_addr | output | 32 | Translated flash address |

## Verification
The hardest case to reach is a warm reset that has to keep state, which differs from the reset value. Boot-select only differs from the configuration-derived value after software has overwritten it, and the remap page is only nonzero after an accepted remap. The stimulus therefore does this in order: it sets a nonzero page through a valid remap, writes a boot-select value opposite to the inverted configuration bit, and asserts reset with each warm cause in turn. It then ends with a full reset and checks that both values go back to their reset values. A stretch of random stimulus afterwards mixes remaps, writes, resets and fetch addresses around the 0x200 boundary. The reference model is compared against the outputs on every clock.

// File: rtl/bootmap_pkg.sv
// Package bootmap_pkg
// Purpose : shared encodings and field positions for the boot select and
//           vector remap unit.
// Assumes : a two-bit boot configuration where bit 1 selects the region and
//           bit 0 low means IAP is enabled.
package bootmap_pkg;

    typedef enum logic [1:0] {
        BCFG_LDR_IAP   = 2'b00,
        BCFG_LDR_PLAIN = 2'b01,
        BCFG_APP_IAP   = 2'b10,
        BCFG_APP_PLAIN = 2'b11
    } boot_cfg_e;

    localparam int STAT_CFG_LSB = 1;

    // True when the configuration enables IAP (vector remap allowed).
    function automatic logic cfg_iap(input logic [1:0] cfg);
        return ~cfg[0];
    endfunction

    // Boot-select reload value: 1 = loader region, taken from the inverse.
    function automatic logic cfg_reload_bs(input logic [1:0] cfg);
        return ~cfg[1];
    endfunction

endpackage

// File: rtl/bootmap_bootsel.sv
// Module bootmap_bootsel
// Purpose : holds the next-boot region bit. A full reset reloads it from the
//           configuration; warm resets (CPU-only or system) keep it; software
//           writes change it outside reset.
// Assumes : reset cause inputs are valid on every edge where rst_n is low.
module bootmap_bootsel
    import bootmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_cpu,
    input  logic       rst_sys,
    input  logic [1:0] boot_cfg,
    input  logic       wr_en,
    input  logic       wr_val,
    output logic       boot_sel
);

    logic warm_rst;

    // Classify the reset as warm when either preserving cause is flagged.
    always_comb begin
        warm_rst = rst_cpu | rst_sys;
    end

    // Boot-select register: reload on full reset, hold on warm reset, else write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (!warm_rst) begin
                boot_sel <= cfg_reload_bs(boot_cfg);
            end
        end else if (wr_en) begin
            boot_sel <= wr_val;
        end
    end

    // R3: a software write lands on the next edge.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (boot_sel == $past(wr_val)));

    // R3: without a write, the bit holds.
    p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(boot_sel));

endmodule

// File: rtl/bootmap_remap.sv
// Module bootmap_remap
// Purpose : holds the vector remap page. A remap command is accepted only in
//           an IAP mode with a page-aligned address inside the page field
//           range; the page comes from the address bits above the offset.
// Assumes : ADDR_W > OFF_W + PAGE_W; warm resets keep the page.
module bootmap_remap #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int OFF_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              iap_en,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic [PAGE_W-1:0] page
);

    localparam int PAGE_HI = OFF_W + PAGE_W - 1;
    localparam int HIGH_W  = ADDR_W - PAGE_HI - 1;

    logic offset_clear;
    logic high_clear;
    logic accept;

    // Address checks: zero page offset and nothing above the page field.
    always_comb begin
        offset_clear = (addr[OFF_W-1:0] == '0);
        high_clear   = (addr[ADDR_W-1:PAGE_HI+1] == {HIGH_W{1'b0}});
    end

    // Acceptance of a remap command.
    always_comb begin
        accept = req & iap_en & offset_clear & high_clear;
    end

    // Page register: cleared on full reset, kept on warm reset, loaded on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (!warm_rst) begin
                page <= '0;
            end
        end else if (accept) begin
            page <= addr[PAGE_HI:OFF_W];
        end
    end

    // R4: an accepted command loads the page field from the address.
    p_accept_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && iap_en && offset_clear && high_clear) |=>
            (page == $past(addr[PAGE_HI:OFF_W])));

    // R5: commands in a non-IAP mode leave the page alone.
    p_noniap_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !iap_en) |=> $stable(page));

    // R6: misaligned or out-of-range commands leave the page alone.
    p_bad_addr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (!offset_clear || !high_clear)) |=> $stable(page));

endmodule

// File: rtl/bootmap_xlate.sv
// Module bootmap_xlate
// Purpose : combinational fetch address translator. In an IAP mode the low
//           vector page (offsets below 2**OFF_W) is redirected to the remap
//           page; everything else passes through.
// Assumes : ADDR_W > OFF_W + PAGE_W.
module bootmap_xlate #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int OFF_W  = 9
) (
    input  logic              iap_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] phys_addr
);

    localparam int MAP_W = OFF_W + PAGE_W;
    localparam int PAD_W = ADDR_W - MAP_W;

    logic              in_vec_page;
    logic [ADDR_W-1:0] mapped;

    // Detect fetches that fall inside the low vector page.
    always_comb begin
        in_vec_page = (fetch_addr[ADDR_W-1:OFF_W] == '0);
    end

    // Build the redirected address, zero padded above the page field.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                mapped = {{PAD_W{1'b0}}, page, fetch_addr[OFF_W-1:0]};
            end
        end else begin : g_nopad
            always_comb begin
                mapped = {page, fetch_addr[OFF_W-1:0]};
            end
        end
    endgenerate

    // Select translated or pass-through address.
    always_comb begin
        phys_addr = (iap_en && in_vec_page) ? mapped : fetch_addr;
    end

    // R8 / R9: pass-through cases must not alter the address.
    always_comb begin
        if (!$isunknown(fetch_addr) && !$isunknown(iap_en)) begin
            if (fetch_addr >= (ADDR_W'(1) << OFF_W)) begin
                p_high_pass_r8: assert (phys_addr == fetch_addr);
            end
            if (!iap_en) begin
                p_plain_pass_r9: assert (phys_addr == fetch_addr);
            end
        end
    end

endmodule

// File: rtl/bootmap_unit.sv
// Module bootmap_unit
// Purpose : top of the boot select and vector remap unit. Ties the boot
//           select bit, the remap page register and the address translator
//           together and builds the read-only status word.
// Assumes : ADDR_W > OFF_W + PAGE_W and ADDR_W > STAT_CFG_LSB + 1.
module bootmap_unit
    import bootmap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int OFF_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_cpu,
    input  logic              rst_sys,
    input  logic [1:0]        boot_cfg,
    input  logic              bs_wr_en,
    input  logic              bs_wr_val,
    input  logic              remap_req,
    input  logic [ADDR_W-1:0] remap_addr,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              boot_sel,
    output logic [PAGE_W-1:0] remap_page,
    output logic [ADDR_W-1:0] status_word,
    output logic [ADDR_W-1:0] phys_addr
);

    localparam int PAGE_HI = OFF_W + PAGE_W - 1;

    logic iap_en;
    logic warm_rst;

    // Decode the configuration and the reset class once for all children.
    always_comb begin
        iap_en   = cfg_iap(boot_cfg);
        warm_rst = rst_cpu | rst_sys;
    end

    bootmap_bootsel i_bootsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_cpu  (rst_cpu),
        .rst_sys  (rst_sys),
        .boot_cfg (boot_cfg),
        .wr_en    (bs_wr_en),
        .wr_val   (bs_wr_val),
        .boot_sel (boot_sel)
    );

    bootmap_remap #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W)
    ) i_remap (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_rst (warm_rst),
        .iap_en   (iap_en),
        .req      (remap_req),
        .addr     (remap_addr),
        .page     (remap_page)
    );

    bootmap_xlate #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W)
    ) i_xlate (
        .iap_en     (iap_en),
        .page       (remap_page),
        .fetch_addr (fetch_addr),
        .phys_addr  (phys_addr)
    );

    // Assemble the status word from the configuration and the page.
    always_comb begin
        status_word = '0;
        status_word[STAT_CFG_LSB+1:STAT_CFG_LSB] = boot_cfg;
        status_word[PAGE_HI:OFF_W]               = remap_page;
    end

    // R7: in an IAP mode the low page carries the remap page above the offset.
    always_comb begin
        if (!$isunknown(fetch_addr) && !$isunknown(boot_cfg) && !$isunknown(remap_page)) begin
            if (iap_en && fetch_addr < (ADDR_W'(1) << OFF_W)) begin
                p_vec_redirect_r7: assert (phys_addr[PAGE_HI:OFF_W] == remap_page);
            end
        end
    end

endmodule

// File: tb/test_bootmap_unit.sv
`timescale 1ns/1ps
// Bench for bootmap_unit: a behavioural reference model updated on each
// rising edge, with every output compared two nanoseconds later.
module test_bootmap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_cpu = 1'b0;
    logic        rst_sys = 1'b0;
    logic [1:0]  boot_cfg = 2'b10;
    logic        bs_wr_en = 1'b0;
    logic        bs_wr_val = 1'b0;
    logic        remap_req = 1'b0;
    logic [31:0] remap_addr = '0;
    logic [31:0] fetch_addr = '0;
    logic        boot_sel;
    logic [11:0] remap_page;
    logic [31:0] status_word;
    logic [31:0] phys_addr;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    string tag = "R1";

    int m_bs = 0;
    int m_page = 0;

    always #5 clk = ~clk;

    bootmap_unit i_bootmap_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_cpu     (rst_cpu),
        .rst_sys     (rst_sys),
        .boot_cfg    (boot_cfg),
        .bs_wr_en    (bs_wr_en),
        .bs_wr_val   (bs_wr_val),
        .remap_req   (remap_req),
        .remap_addr  (remap_addr),
        .fetch_addr  (fetch_addr),
        .boot_sel    (boot_sel),
        .remap_page  (remap_page),
        .status_word (status_word),
        .phys_addr   (phys_addr)
    );

    // Reference model, written straight from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            if (!rst_cpu && !rst_sys) begin           // R1 full reset
                m_bs   <= boot_cfg[1] ? 0 : 1;
                m_page <= 0;
            end                                        // R2 warm reset keeps
        end else begin
            if (bs_wr_en) m_bs <= bs_wr_val;           // R3
            if (remap_req && boot_cfg[0] == 1'b0 &&
                remap_addr % 512 == 0 && remap_addr < 32'h0020_0000)
                m_page <= remap_addr / 512;            // R4, R5, R6
        end
    end

    task automatic cmp(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: wait past the edge, compare everything, then caller drives.
    task automatic tick();
        longint exp_phys;
        @(posedge clk);
        #2;
        cmp({tag, " boot_sel"}, boot_sel, m_bs);
        cmp({tag, " remap_page"}, remap_page, m_page);
        if (boot_cfg[0] == 1'b1) begin
            cmp("R9 phys_addr", phys_addr, fetch_addr);
        end else if (fetch_addr >= 32'h200) begin
            cmp("R8 phys_addr", phys_addr, fetch_addr);
        end else begin
            exp_phys = longint'(m_page) * 512 + (fetch_addr % 512);
            cmp("R7 phys_addr", phys_addr, exp_phys);
        end
        cmp("R10 status_word", status_word,
            longint'(m_page) * 512 + longint'(boot_cfg) * 2);
    endtask

    task automatic remap(input logic [31:0] a);
        remap_req = 1'b1; remap_addr = a; tick();
        remap_req = 1'b0; tick();
    endtask

    initial begin
        // R1: full reset, application region with IAP -> boot_sel 0
        tag = "R1"; tick(); tick();
        boot_cfg = 2'b00; tick();                      // loader region -> 1
        rst_n = 1'b1;
        // R3: software writes and holds
        tag = "R3";
        bs_wr_en = 1'b1; bs_wr_val = 1'b0; tick();
        bs_wr_en = 1'b0; bs_wr_val = 1'b1; tick(); tick();
        bs_wr_en = 1'b1; tick();
        bs_wr_en = 1'b0; tick();
        // R4: valid remap in IAP mode, page 0x92
        tag = "R4";
        remap(32'h0001_2400);
        foreach (fetch_addr[i]) begin end
        fetch_addr = 32'h0000_0000; tick();            // R7
        fetch_addr = 32'h0000_01FC; tick();            // R7
        fetch_addr = 32'h0000_0200; tick();            // R8 boundary
        fetch_addr = 32'h0000_1000; tick();            // R8
        fetch_addr = 32'h0000_0044;
        remap(32'h001F_FE00);                          // R4 top page 0xFFF
        // R6: misaligned and out-of-range commands rejected
        tag = "R6";
        remap(32'h0000_4402);
        remap(32'h0000_4500);
        remap(32'h0020_0000);
        // R5: non-IAP mode rejects commands and passes addresses (R9)
        tag = "R5";
        boot_cfg = 2'b01;
        remap(32'h0000_0400);
        fetch_addr = 32'h0000_0010; tick();
        // R2: warm resets keep a software-changed boot_sel and the page
        tag = "R2";
        bs_wr_en = 1'b1; bs_wr_val = 1'b0; tick(); bs_wr_en = 1'b0;
        rst_n = 1'b0; rst_cpu = 1'b1; tick(); tick();
        rst_cpu = 1'b0; rst_sys = 1'b1; tick();
        rst_sys = 1'b0; rst_n = 1'b1; tick();
        // R1: full reset reloads and clears
        tag = "R1";
        rst_n = 1'b0; tick();
        rst_n = 1'b1; boot_cfg = 2'b10; tick();
        // Random mix over all requirements
        tag = "R4";
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = $urandom_range(0, 15);
            rst_n      = (sel != 0);
            rst_cpu    = $urandom_range(0, 1);
            rst_sys    = $urandom_range(0, 1);
            boot_cfg   = 2'($urandom_range(0, 3));
            bs_wr_en   = $urandom_range(0, 1);
            bs_wr_val  = $urandom_range(0, 1);
            remap_req  = $urandom_range(0, 1);
            remap_addr = (sel < 8) ? (32'($urandom_range(0, 4095)) << 9) : $urandom;
            fetch_addr = 32'($urandom_range(0, 32'h3FF));
            tick();
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        #1_000_000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule